// File: doc/BRIEF.md
# Write-Ordering Pipeline Interlock

This unit tracks instructions through a ten-stage in-order pipe: one decode slot, three register-read slots, and six execute slots. It keeps writes to the same data register in program order. An instruction can write its destination in the first, second or third execute slot. A younger instruction with an early write could therefore land before an older instruction with a late write to the same register. To prevent this, the unit holds the younger instruction in the decode slot. On every held cycle it sends an empty slot into the first read stage. The younger instruction is released on the first cycle in which its write can no longer come before the older one.

Instructions arrive on a valid/ready stream. A source raises `in_valid` with a payload. The payload is taken into the decode slot on a rising clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must keep `in_valid` high and the payload unchanged until it is taken. `in_ready` depends only on the pipe's own state and never on the current input. Dropping `in_valid` for a cycle is allowed; the decode slot then fills with an empty slot. The unit reports which stages are occupied and the tag held in each. In every cycle, each execute write slot reports a commit with the register index and tag of the instruction writing there.

Top module: `wo_interlock`

## Requirements
- R1: After reset every stage is empty, `stall` is low, `in_ready` is high and no commit lane is active.
- R2: Stages are numbered 0 (decode), 1 to 3 (read), 4 to 9 (execute 1 to 6). Bit k of `stage_vld` and slice k of `stage_tag` describe stage k. A payload taken at an edge is in stage 0 after that edge. With no hold, it then moves one stage per clock and leaves after stage 9.
- R3: Write-phase code 0, 1 or 2 selects a write in stage 4, 5 or 6. Code 3 is treated as code 2. Commit lane p is bit p of `cmt_vld`, with slice p of `cmt_dst` and `cmt_tag`. It is high in the cycle when a write-enabled instruction with phase code p sits in stage 4+p. An instruction with `in_we` low never commits.
- R4: Let the instruction in stage 0 write register d with code y. Let an older instruction at stage s (s ≥ 1) write the same d with code o. `stall` is high while y + s ≤ o, and `in_ready` is its inverse.
- R5: A code-0 write directly behind a code-2 write to the same register is held 2 cycles. It reaches stage 4 in the cycle when the older instruction is in stage 7.
- R6: A code-1 write directly behind a code-2 write is held 1 cycle. A code-0 write one stage further behind a code-2 write is held 1 cycle. A code-0 write directly behind a code-1 write is held 1 cycle.
- R7: No hold occurs in any of these cases: the registers differ, the younger code is equal to or greater than the older one, either instruction has its write-enable low, or the older write is already three or more stages ahead.
- R8: During a hold, stage 0 keeps its contents, stage 1 receives an empty slot, and stages 2 to 9 advance. Instructions waiting at the input enter only after the held one moves on.
- R9: Commits to the same register occur in program order, and never two in the same cycle.
- R10: `stall` is never high for more than 2 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Decode slot can take the offered instruction |
| in_we | input | 1 | Instruction writes its destination register |
| in_dst | input | 3 | Destination register index |
| in_wph | input | 2 | Write-phase code (0, 1, 2; 3 treated as 2) |
| in_tag | input | 8 | Instruction tag |
| stall | output | 1 | Decode hold active |
| stage_vld | output | 10 | Occupancy per stage, bit k = stage k |
| stage_tag | output | 80 | Tag per stage, bits 8k+7:8k = stage k |
| cmt_vld | output | 3 | Commit lane active, bit p = write phase p |
| cmt_dst | output | 9 | Register index per commit lane, 3 bits per lane |
| cmt_tag | output | 24 | Tag per commit lane, 8 bits per lane |

## Verification
The bench targets the exact length of each hold. A hazard rule that is off by one would let a fast write land in the same cycle as the slow one, or before it, or would waste one bubble. Separate cases cover an unrelated instruction or a dropped-valid gap between the two writers, which shortens the hold. It also tries an out-of-range phase code, writes with the enable low, and a later-phase younger write. A design that mishandled any of these would hold when it must not, or let a commit land out of order. Long runs of random traffic on four registers check that instructions behind a held one stay queued and are never lost, duplicated or reordered.

// File: rtl/wo_ilk_pkg.sv
`timescale 1ns/1ps
package wo_ilk_pkg;
  parameter int REG_IDX_W = 3;
  parameter int TAG_W     = 8;
  parameter int NUM_WPH   = 3;
  parameter int NUM_FRONT = 4;
  parameter int NUM_BACK  = 6;

  localparam int PH_W       = $clog2(NUM_WPH);
  localparam int NUM_STAGES = NUM_FRONT + NUM_BACK;
  localparam int FIRST_EXEC = NUM_FRONT;
  localparam int HAZ_DEPTH  = NUM_WPH - 1;

  typedef struct packed {
    logic                 vld;
    logic                 we;
    logic [REG_IDX_W-1:0] dst;
    logic [PH_W-1:0]      ph;
    logic [TAG_W-1:0]     tag;
  } slot_t;

  localparam slot_t EMPTY_SLOT = '0;
endpackage

// File: rtl/wo_stage_reg.sv
`timescale 1ns/1ps
module wo_stage_reg
  import wo_ilk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  slot_t d,
  output slot_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= EMPTY_SLOT;
    else if (en) q <= d;
  end
endmodule

// File: rtl/wo_waw_detect.sv
`timescale 1ns/1ps
module wo_waw_detect
  import wo_ilk_pkg::*;
#(
  parameter int DEPTH = HAZ_DEPTH
)(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            d2_vld,
  input  logic                            d2_we,
  input  logic [REG_IDX_W-1:0]            d2_dst,
  input  logic [PH_W-1:0]                 d2_ph,
  input  logic [DEPTH-1:0]                ah_vld,
  input  logic [DEPTH-1:0]                ah_we,
  input  logic [DEPTH-1:0][REG_IDX_W-1:0] ah_dst,
  input  logic [DEPTH-1:0][PH_W-1:0]      ah_ph,
  output logic                            hold
);
  logic [DEPTH-1:0] hit;

  // entry i sits i+1 stages ahead of decode; it still overtakes
  // a younger write while young_phase + distance <= old_phase
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic same_reg, too_close;
    assign same_reg  = ah_vld[i] && ah_we[i] && (ah_dst[i] == d2_dst);
    assign too_close = (int'(d2_ph) + i + 1) <= int'(ah_ph[i]);
    assign hit[i]    = d2_vld && d2_we && same_reg && too_close;
  end

  assign hold = |hit;

  int unsigned hold_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_run <= 0;
    else if (hold) hold_run <= hold_run + 1;
    else           hold_run <= 0;
  end

  AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (hold_run < DEPTH)); // R10
endmodule

// File: rtl/wo_commit_tap.sv
`timescale 1ns/1ps
module wo_commit_tap
  import wo_ilk_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  slot_t                        ex [NUM_WPH],
  output logic [NUM_WPH-1:0]           c_vld,
  output logic [NUM_WPH*REG_IDX_W-1:0] c_dst,
  output logic [NUM_WPH*TAG_W-1:0]     c_tag
);
  for (genvar p = 0; p < NUM_WPH; p++) begin : g_lane
    assign c_vld[p] = ex[p].vld && ex[p].we && (ex[p].ph == PH_W'(p));
    assign c_dst[p*REG_IDX_W +: REG_IDX_W] = ex[p].dst;
    assign c_tag[p*TAG_W +: TAG_W]         = ex[p].tag;
  end

  for (genvar a = 0; a < NUM_WPH; a++) begin : g_pa
    for (genvar b = a + 1; b < NUM_WPH; b++) begin : g_pb
      AST_NO_SAME_CYCLE_WAW: assert property (@(posedge clk) disable iff (!rst_n)
        (c_vld[a] && c_vld[b]) |-> (ex[a].dst != ex[b].dst)); // R9
    end
  end
endmodule

// File: rtl/wo_interlock.sv
`timescale 1ns/1ps
module wo_interlock
  import wo_ilk_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic                                  in_we,
  input  logic [REG_IDX_W-1:0]                  in_dst,
  input  logic [PH_W-1:0]                       in_wph,
  input  logic [TAG_W-1:0]                      in_tag,
  output logic                                  stall,
  output logic [NUM_STAGES-1:0]                 stage_vld,
  output logic [NUM_STAGES*TAG_W-1:0]           stage_tag,
  output logic [NUM_WPH-1:0]                    cmt_vld,
  output logic [NUM_WPH*REG_IDX_W-1:0]          cmt_dst,
  output logic [NUM_WPH*TAG_W-1:0]              cmt_tag
);
  slot_t                 stg_q [NUM_STAGES];
  slot_t                 stg_d [NUM_STAGES];
  logic [NUM_STAGES-1:0] stg_en;
  slot_t                 in_slot;
  logic                  hold;

  // capture path: out-of-range phase codes fold onto the last phase
  always_comb begin
    in_slot     = EMPTY_SLOT;
    in_slot.vld = in_valid;
    in_slot.we  = in_valid && in_we;
    in_slot.dst = in_dst;
    in_slot.ph  = (int'(in_wph) > NUM_WPH - 1) ? PH_W'(NUM_WPH - 1) : in_wph;
    in_slot.tag = in_tag;
  end

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_dec
      assign stg_d[k]  = in_slot;
      assign stg_en[k] = !hold;
    end else if (k == 1) begin : g_bub
      assign stg_d[k]  = hold ? EMPTY_SLOT : stg_q[0];
      assign stg_en[k] = 1'b1;
    end else begin : g_flow
      assign stg_d[k]  = stg_q[k-1];
      assign stg_en[k] = 1'b1;
    end

    wo_stage_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (stg_en[k]),
      .d     (stg_d[k]),
      .q     (stg_q[k])
    );

    assign stage_vld[k]              = stg_q[k].vld;
    assign stage_tag[k*TAG_W +: TAG_W] = stg_q[k].tag;
  end

  logic [HAZ_DEPTH-1:0]                ah_vld, ah_we;
  logic [HAZ_DEPTH-1:0][REG_IDX_W-1:0] ah_dst;
  logic [HAZ_DEPTH-1:0][PH_W-1:0]      ah_ph;

  for (genvar i = 0; i < HAZ_DEPTH; i++) begin : g_ahead
    assign ah_vld[i] = stg_q[i+1].vld;
    assign ah_we[i]  = stg_q[i+1].we;
    assign ah_dst[i] = stg_q[i+1].dst;
    assign ah_ph[i]  = stg_q[i+1].ph;
  end

  wo_waw_detect #(.DEPTH(HAZ_DEPTH)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .d2_vld (stg_q[0].vld),
    .d2_we  (stg_q[0].we),
    .d2_dst (stg_q[0].dst),
    .d2_ph  (stg_q[0].ph),
    .ah_vld (ah_vld),
    .ah_we  (ah_we),
    .ah_dst (ah_dst),
    .ah_ph  (ah_ph),
    .hold   (hold)
  );

  slot_t ex_slots [NUM_WPH];
  for (genvar p = 0; p < NUM_WPH; p++) begin : g_ex
    assign ex_slots[p] = stg_q[FIRST_EXEC + p];
  end

  wo_commit_tap u_commit (
    .clk   (clk),
    .rst_n (rst_n),
    .ex    (ex_slots),
    .c_vld (cmt_vld),
    .c_dst (cmt_dst),
    .c_tag (cmt_tag)
  );

  assign stall    = hold;
  assign in_ready = !hold;

  AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (stage_vld[0] && stage_tag[TAG_W-1:0] == $past(in_tag))); // R2
  AST_BUBBLE_BEHIND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stage_vld[1]); // R8
  AST_D2_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(stg_q[0])); // R8
endmodule

// File: tb/wo_interlock_tb.sv
`timescale 1ns/1ps
module wo_interlock_tb;
  import wo_ilk_pkg::*;

  localparam int NS = NUM_STAGES;
  localparam int MAXI = 1024;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 8 ns period, 125 MHz

  logic                         rst_n;
  logic                         in_valid, in_ready, in_we;
  logic [REG_IDX_W-1:0]         in_dst;
  logic [PH_W-1:0]              in_wph;
  logic [TAG_W-1:0]             in_tag;
  logic                         stall;
  logic [NS-1:0]                stage_vld;
  logic [NS*TAG_W-1:0]          stage_tag;
  logic [NUM_WPH-1:0]           cmt_vld;
  logic [NUM_WPH*REG_IDX_W-1:0] cmt_dst;
  logic [NUM_WPH*TAG_W-1:0]     cmt_tag;

  wo_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_we(in_we), .in_dst(in_dst), .in_wph(in_wph), .in_tag(in_tag),
    .stall(stall), .stage_vld(stage_vld), .stage_tag(stage_tag),
    .cmt_vld(cmt_vld), .cmt_dst(cmt_dst), .cmt_tag(cmt_tag)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model: per-instruction timeline (accept time, release time)
  int m_dst [MAXI];
  int m_ph  [MAXI];
  bit m_we  [MAXI];
  int m_acc [MAXI];
  int m_rel [MAXI];
  int ni = 0;
  int st_n = 0;
  int last_id [8];
  int stall_seen = 0, stall_run = 0;

  typedef struct { bit v; bit we; int dst; int ph; } stim_t;
  stim_t sq[$];

  bit watch_en = 0, watch_hit = 0;
  int watch_old = 0, watch_young = 0;

  function automatic int lo_id();
    return (ni > 40) ? ni - 40 : 0;
  endfunction

  function automatic bit model_stall(int n);
    for (int id = lo_id(); id < ni; id++)
      if (m_acc[id] <= n && n < m_rel[id]) return 1;
    return 0;
  endfunction

  function automatic int tag_at(int k);
    return int'(stage_tag[k*TAG_W +: TAG_W]);
  endfunction

  task automatic compare_state();
    int e_vld [NS];
    int e_tag [NS];
    int e_cv [NUM_WPH];
    int e_cd [NUM_WPH];
    int e_ct [NUM_WPH];
    bit e_st;
    for (int k = 0; k < NS; k++) begin e_vld[k] = 0; e_tag[k] = 0; end
    for (int p = 0; p < NUM_WPH; p++) begin e_cv[p] = 0; e_cd[p] = 0; e_ct[p] = 0; end
    for (int id = lo_id(); id < ni; id++) begin
      if (m_acc[id] <= st_n) begin
        int sg;
        sg = (st_n <= m_rel[id]) ? 0 : st_n - m_rel[id];
        if (sg < NS) begin
          e_vld[sg] = 1;
          e_tag[sg] = id & 255;
          if (m_we[id] && sg == FIRST_EXEC + m_ph[id]) begin
            e_cv[m_ph[id]] = 1;
            e_cd[m_ph[id]] = m_dst[id];
            e_ct[m_ph[id]] = id & 255;
          end
        end
      end
    end
    e_st = model_stall(st_n);
    check(stall == e_st, "R4", "stall", int'(stall), int'(e_st));
    check(in_ready == !e_st, "R4", "in_ready", int'(in_ready), int'(!e_st));
    for (int k = 0; k < NS; k++) begin
      check(int'(stage_vld[k]) == e_vld[k], "R2 R8", $sformatf("stage %0d valid", k),
            int'(stage_vld[k]), e_vld[k]);
      if (e_vld[k] != 0)
        check(tag_at(k) == e_tag[k], "R2 R8", $sformatf("stage %0d tag", k), tag_at(k), e_tag[k]);
    end
    for (int p = 0; p < NUM_WPH; p++) begin
      check(int'(cmt_vld[p]) == e_cv[p], "R3", $sformatf("commit lane %0d valid", p),
            int'(cmt_vld[p]), e_cv[p]);
      if (e_cv[p] != 0) begin
        int ad, at;
        ad = int'(cmt_dst[p*REG_IDX_W +: REG_IDX_W]);
        at = int'(cmt_tag[p*TAG_W +: TAG_W]);
        check(ad == e_cd[p], "R3", $sformatf("commit lane %0d reg", p), ad, e_cd[p]);
        check(at == e_ct[p], "R3", $sformatf("commit lane %0d tag", p), at, e_ct[p]);
      end
    end
    // R9: program order of commits per register, observed at the ports
    for (int p = 0; p < NUM_WPH; p++) begin
      if (cmt_vld[p]) begin
        int d, t, id;
        d  = int'(cmt_dst[p*REG_IDX_W +: REG_IDX_W]);
        t  = int'(cmt_tag[p*TAG_W +: TAG_W]);
        id = (ni - 1) - (((ni - 1) - t) & 255);
        check(id > last_id[d], "R9", $sformatf("commit order reg %0d", d), id, last_id[d] + 1);
        last_id[d] = id;
      end
    end
    // R10
    if (stall) begin
      stall_seen++;
      stall_run++;
      check(stall_run <= 2, "R10", "consecutive stall cycles", stall_run, 2);
    end else begin
      stall_run = 0;
    end
    // R5 alignment: younger in E1 while older in E4
    if (watch_en && stage_vld[FIRST_EXEC] && tag_at(FIRST_EXEC) == (watch_young & 255)) begin
      watch_hit = 1;
      check(stage_vld[FIRST_EXEC+3] && tag_at(FIRST_EXEC+3) == (watch_old & 255),
            "R5", "older tag in E4 when younger in E1", tag_at(FIRST_EXEC+3), watch_old & 255);
    end
  endtask

  task automatic drive_head();
    in_valid = 1'b0;
    if (sq.size() == 0) return;
    if (!sq[0].v) begin
      void'(sq.pop_front());
      return;
    end
    in_valid = 1'b1;
    in_we    = sq[0].we;
    in_dst   = REG_IDX_W'(sq[0].dst);
    in_wph   = PH_W'(sq[0].ph);
    in_tag   = TAG_W'(ni & 255);
    if (!model_stall(st_n)) begin
      int r, yp;
      yp = (sq[0].ph > NUM_WPH - 1) ? NUM_WPH - 1 : sq[0].ph;
      m_dst[ni] = sq[0].dst;
      m_ph[ni]  = yp;
      m_we[ni]  = sq[0].we;
      m_acc[ni] = st_n + 1;
      r = st_n + 1;
      for (int j = lo_id(); j < ni; j++)
        if (m_we[j] && sq[0].we && m_dst[j] == sq[0].dst)
          if (m_rel[j] + m_ph[j] - yp + 1 > r) r = m_rel[j] + m_ph[j] - yp + 1;
      m_rel[ni] = r;
      ni++;
      void'(sq.pop_front());
    end
  endtask

  task automatic cycle_once();
    compare_state();
    drive_head();
    @(posedge clk);
    st_n++;
    @(negedge clk);
  endtask

  task automatic push(bit v, bit we, int dst, int ph);
    stim_t s;
    s.v = v; s.we = we; s.dst = dst; s.ph = ph;
    sq.push_back(s);
  endtask

  task automatic run_scn(string req, int exp_stalls);
    stall_seen = 0;
    while (sq.size() > 0) cycle_once();
    repeat (14) cycle_once();
    check(stall_seen == exp_stalls, req, "total stall cycles", stall_seen, exp_stalls);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) last_id[r] = -1;
    rst_n = 1'b0; in_valid = 1'b0; in_we = 1'b0;
    in_dst = '0; in_wph = '0; in_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    st_n = 0;

    check(stall == 1'b0, "R1", "stall after reset", int'(stall), 0);
    check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    check(stage_vld == '0, "R1", "occupancy after reset", int'(stage_vld), 0);
    check(cmt_vld == '0, "R1", "commits after reset", int'(cmt_vld), 0);

    // R5: late write then early write to the same register
    watch_old = ni; watch_young = ni + 1; watch_en = 1; watch_hit = 0;
    push(1, 1, 3, 2); push(1, 1, 3, 0);
    run_scn("R5", 2);
    watch_en = 0;
    check(watch_hit, "R5", "younger reached E1", int'(watch_hit), 1);

    // R6 cases
    push(1, 1, 1, 2); push(1, 1, 1, 1);
    run_scn("R6", 1);
    push(1, 1, 1, 2); push(1, 1, 5, 0); push(1, 1, 1, 0);
    run_scn("R6", 1);
    push(1, 1, 2, 1); push(1, 1, 2, 0);
    run_scn("R6", 1);
    push(1, 1, 6, 2); push(0, 0, 0, 0); push(1, 1, 6, 0);
    run_scn("R6", 1);

    // R7 no-hold cases
    push(1, 1, 4, 2); push(1, 1, 6, 0);
    run_scn("R7", 0);
    push(1, 1, 4, 0); push(1, 1, 4, 2); push(1, 1, 5, 1); push(1, 1, 5, 1);
    run_scn("R7", 0);
    push(1, 0, 4, 2); push(1, 1, 4, 0); push(1, 1, 7, 2); push(1, 0, 7, 0);
    run_scn("R7", 0);
    push(1, 1, 4, 2); push(0, 0, 0, 0); push(0, 0, 0, 0); push(1, 1, 4, 0);
    run_scn("R7", 0);

    // R3: phase code 3 acts as the last phase
    push(1, 1, 2, 3); push(1, 1, 2, 0);
    run_scn("R3", 2);

    // R8: followers wait behind a held instruction
    push(1, 1, 0, 2); push(1, 1, 0, 0); push(1, 1, 7, 0); push(1, 1, 7, 0);
    run_scn("R8", 2);

    // random traffic on a small register set
    for (int i = 0; i < 400; i++)
      push($urandom_range(0, 4) != 0, $urandom_range(0, 9) != 0,
           $urandom_range(0, 3), $urandom_range(0, 3));
    while (sq.size() > 0) cycle_once();
    repeat (14) cycle_once();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule